// File: doc/BRIEF.md
# Keyed Error-Control Register

This block is a 32-bit memory-mapped control register for the error-handling features that protect a buffer RAM. A simple bus port delivers a write strobe, the write data and a privilege qualifier. The register keeps four active fields.

Three of the fields are 4 bits wide and respond only to agreed code patterns. In two of them, 5h means "off" and Ah means "on", and a write of any other pattern is dropped without notice. The detection field takes any value; 5h is the only value that turns detection off. The fourth field is a single bit that places the check bits of the RAM into its address frame. The correction-mode field and the memory-map bit change only on privileged writes.

The stored fields are decoded into four enable outputs. The register also gates an incoming single-bit-error pulse onto an event output. Reads return the stored raw field values, and all unused bit positions read as zero. The codec and the RAM are outside this block.

Top module: `errctl_reg`

## Requirements
- R1: A synchronous active-high reset makes the read value 0x050A0005: event field 5h, mode field Ah, map bit 0, detect field 5h.
- R2: Bits 27:24 hold the event field. Any write of 5h or Ah is stored, privileged or not. Any other value leaves the field unchanged.
- R3: Bits 19:16 hold the mode field. A write of 5h or Ah is stored only when the write is privileged. Other values, and all unprivileged writes, leave the field unchanged.
- R4: Bits 3:0 hold the detect field. Any write stores the value, privileged or not. `det_en` is high exactly when the field is not 5h.
- R5: Bit 8 is the map bit. Only a privileged write changes it. `chk_map_en` equals the stored bit.
- R6: Bits 31:28, 23:20, 15:9 and 7:4 always read as 0, whatever was written to them.
- R7: Each field is judged on its own within a write. An unprivileged write still updates the event and detect fields while the mode field and the map bit stay unchanged.
- R8: `corr_en` is high exactly when the mode field is Ah and `det_en` is high.
- R9: `sbe_evt_en` is high exactly when the event field is Ah. `sbe_evt_out` equals `sbe_pulse_in` AND `sbe_evt_en` in the same cycle.
- R10: A write changes the read value and the enables at the clock edge that samples the strobe, not before it. Reads return the stored 4-bit field values, not decoded flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_priv | input | 1 | Write is issued in privilege mode |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read value: raw fields, reserved bits zero |
| sbe_pulse_in | input | 1 | Single-bit error detected, from the codec |
| det_en | output | 1 | Error detection enable |
| corr_en | output | 1 | Single-bit correction enable |
| sbe_evt_en | output | 1 | Single-bit error event enable |
| chk_map_en | output | 1 | Check bits mapped into the RAM frame |
| sbe_evt_out | output | 1 | Gated single-bit error event |

## Verification
A directed opening covers the reset value and a single unprivileged write that mixes key codes and non-key codes. That write shows whether fields are judged one by one and whether privilege gating applies to the right fields. It also shows that the read value does not change until the edge after the strobe. A long mixed phase then drives writes whose fields are each drawn from 5h, Ah or an arbitrary nibble, with privilege and reserved-bit contents chosen at random. This phase separates key-only fields from the free detection field and separates the two pulse gates. A behavioural model is compared against every output on every cycle.

// File: rtl/errctl_pkg.sv
package errctl_pkg;

    localparam int REG_W   = 32;
    localparam int FLD_W   = 4;

    localparam logic [FLD_W-1:0] KEY_OFF = 4'h5;
    localparam logic [FLD_W-1:0] KEY_ON  = 4'hA;

    localparam int EVT_LSB  = 24;
    localparam int MODE_LSB = 16;
    localparam int MAP_BIT  = 8;
    localparam int DET_LSB  = 0;

    typedef enum logic {
        ACCEPT_KEYS,
        ACCEPT_ANY
    } accept_e;

    typedef struct packed {
        logic [FLD_W-1:0] evt;
        logic [FLD_W-1:0] mode;
        logic             map;
        logic [FLD_W-1:0] det;
    } ctl_state_t;

    typedef struct packed {
        logic det;
        logic corr;
        logic evt;
        logic map;
    } ctl_enables_t;

    function automatic logic is_key(input logic [FLD_W-1:0] v);
        return (v == KEY_OFF) || (v == KEY_ON);
    endfunction

    function automatic logic [REG_W-1:0] pack_read(input ctl_state_t s);
        logic [REG_W-1:0] r;
        r = '0;
        r[EVT_LSB  +: FLD_W] = s.evt;
        r[MODE_LSB +: FLD_W] = s.mode;
        r[MAP_BIT]           = s.map;
        r[DET_LSB  +: FLD_W] = s.det;
        return r;
    endfunction

endpackage

// File: rtl/errctl_keyed_field.sv
module errctl_keyed_field
    import errctl_pkg::*;
#(
    parameter accept_e          ACCEPT    = ACCEPT_KEYS,
    parameter bit               PRIV_ONLY = 1'b0,
    parameter logic [FLD_W-1:0] RST_VAL   = KEY_OFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_priv,
    input  logic [FLD_W-1:0] wr_val,
    output logic [FLD_W-1:0] q
);

    logic code_ok;
    logic mode_ok;
    logic take;

    generate
        if (ACCEPT == ACCEPT_KEYS) begin : g_keys
            assign code_ok = is_key(wr_val);
        end else begin : g_any
            assign code_ok = 1'b1;
        end
        if (PRIV_ONLY) begin : g_priv
            assign mode_ok = wr_priv;
        end else begin : g_open
            assign mode_ok = 1'b1;
        end
    endgenerate

    assign take = wr_en && code_ok && mode_ok;

    always_ff @(posedge clk) begin
        if (rst)       q <= RST_VAL;
        else if (take) q <= wr_val;
    end

    generate
        if (ACCEPT == ACCEPT_KEYS) begin : g_key_chk
            // R2
            key_reject_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_en && !is_key(wr_val)) |=> $stable(q));
            // R3
            key_only_chk: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> is_key(q));
        end
        if (PRIV_ONLY) begin : g_priv_chk
            // R3
            priv_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_en && !wr_priv) |=> $stable(q));
        end
    endgenerate

endmodule

// File: rtl/errctl_decode.sv
module errctl_decode
    import errctl_pkg::*;
(
    input  ctl_state_t   st,
    input  logic         sbe_pulse,
    output ctl_enables_t en,
    output logic         sbe_evt
);

    always_comb begin
        en.det  = (st.det != KEY_OFF);
        en.corr = (st.mode == KEY_ON) && en.det;
        en.evt  = (st.evt == KEY_ON);
        en.map  = st.map;
        sbe_evt = sbe_pulse && en.evt;
    end

endmodule

// File: rtl/errctl_reg.sv
module errctl_reg
    import errctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_priv,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             sbe_pulse_in,
    output logic             det_en,
    output logic             corr_en,
    output logic             sbe_evt_en,
    output logic             chk_map_en,
    output logic             sbe_evt_out
);

    ctl_state_t   st;
    ctl_enables_t en;
    logic         map_q;

    errctl_keyed_field #(.ACCEPT(ACCEPT_KEYS), .PRIV_ONLY(1'b0), .RST_VAL(KEY_OFF)) u_evt (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_priv(wr_priv),
        .wr_val(wr_data[EVT_LSB +: FLD_W]), .q(st.evt)
    );

    errctl_keyed_field #(.ACCEPT(ACCEPT_KEYS), .PRIV_ONLY(1'b1), .RST_VAL(KEY_ON)) u_mode (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_priv(wr_priv),
        .wr_val(wr_data[MODE_LSB +: FLD_W]), .q(st.mode)
    );

    errctl_keyed_field #(.ACCEPT(ACCEPT_ANY), .PRIV_ONLY(1'b0), .RST_VAL(KEY_OFF)) u_det (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_priv(wr_priv),
        .wr_val(wr_data[DET_LSB +: FLD_W]), .q(st.det)
    );

    always_ff @(posedge clk) begin
        if (rst)                    map_q <= 1'b0;
        else if (wr_en && wr_priv)  map_q <= wr_data[MAP_BIT];
    end

    assign st.map = map_q;

    errctl_decode u_dec (
        .st(st), .sbe_pulse(sbe_pulse_in), .en(en), .sbe_evt(sbe_evt_out)
    );

    assign rd_data    = pack_read(st);
    assign det_en     = en.det;
    assign corr_en    = en.corr;
    assign sbe_evt_en = en.evt;
    assign chk_map_en = en.map;

    logic unused_rsv;
    assign unused_rsv = ^{wr_data[31:28], wr_data[23:20], wr_data[15:9], wr_data[7:4]};

    // R8
    corr_needs_det_chk: assert property (@(posedge clk) disable iff (rst)
        corr_en |-> det_en);
    // R9
    evt_gate_chk: assert property (@(posedge clk) disable iff (rst)
        sbe_evt_out |-> (sbe_pulse_in && sbe_evt_en));
    // R5
    map_priv_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_priv) |=> $stable(chk_map_en));
    // R1
    reset_val_chk: assert property (@(posedge clk)
        rst |=> (rd_data == 32'h050A_0005));

endmodule

// File: tb/errctl_reg_tb.sv
module errctl_reg_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_priv = 1'b0;
    logic [31:0] wr_data = '0;
    logic        sbe_pulse_in = 1'b0;
    logic [31:0] rd_data;
    logic        det_en, corr_en, sbe_evt_en, chk_map_en, sbe_evt_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    int m_evt = 5, m_mode = 10, m_det = 5, m_map = 0;

    always #5 clk = ~clk;

    errctl_reg u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_priv(wr_priv), .wr_data(wr_data),
        .rd_data(rd_data), .sbe_pulse_in(sbe_pulse_in), .det_en(det_en),
        .corr_en(corr_en), .sbe_evt_en(sbe_evt_en), .chk_map_en(chk_map_en),
        .sbe_evt_out(sbe_evt_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read();
        return (32'(m_evt) << 24) | (32'(m_mode) << 16) | (32'(m_map) << 8) | 32'(m_det);
    endfunction

    task automatic compare_all();
        bit e_det, e_corr, e_evt, e_out;
        e_det  = (m_det != 5);
        e_corr = (m_mode == 10) && e_det;
        e_evt  = (m_evt == 10);
        e_out  = sbe_pulse_in && e_evt;
        check(rd_data[27:24] == 4'(m_evt),  "R2 event field",  32'(rd_data[27:24]), 32'(m_evt));
        check(rd_data[19:16] == 4'(m_mode), "R3 mode field",   32'(rd_data[19:16]), 32'(m_mode));
        check(rd_data[3:0]   == 4'(m_det),  "R4 detect field", 32'(rd_data[3:0]), 32'(m_det));
        check(rd_data[8]     == 1'(m_map),  "R5 map bit",      32'(rd_data[8]), 32'(m_map));
        check({rd_data[31:28], rd_data[23:20], rd_data[15:9], rd_data[7:4]} == '0,
              "R6 reserved zero", rd_data, model_read());
        check(det_en == e_det,         "R4 det_en",      32'(det_en), 32'(e_det));
        check(corr_en == e_corr,       "R8 corr_en",     32'(corr_en), 32'(e_corr));
        check(sbe_evt_en == e_evt,     "R9 sbe_evt_en",  32'(sbe_evt_en), 32'(e_evt));
        check(chk_map_en == 1'(m_map), "R5 chk_map_en",  32'(chk_map_en), 32'(m_map));
        check(sbe_evt_out == e_out,    "R9 sbe_evt_out", 32'(sbe_evt_out), 32'(e_out));
    endtask

    task automatic model_edge();
        int v;
        if (rst) begin
            m_evt = 5; m_mode = 10; m_det = 5; m_map = 0;
        end else if (wr_en) begin
            v = int'(wr_data[27:24]);
            if (v == 5 || v == 10) m_evt = v;
            v = int'(wr_data[19:16]);
            if (wr_priv && (v == 5 || v == 10)) m_mode = v;
            m_det = int'(wr_data[3:0]);
            if (wr_priv) m_map = int'(wr_data[8]);
        end
    endtask

    // one cycle: drive at negedge, compare, then advance the model at posedge
    task automatic cycle(input bit r, input bit we, input bit pv, input logic [31:0] d, input bit sp);
        @(negedge clk);
        rst = r; wr_en = we; wr_priv = pv; wr_data = d; sbe_pulse_in = sp;
        #1;
        compare_all();
        @(posedge clk);
        model_edge();
    endtask

    function automatic logic [3:0] pick_nib();
        int s = $urandom_range(0, 2);
        if (s == 0) return 4'h5;
        if (s == 1) return 4'hA;
        return 4'($urandom_range(0, 15));
    endfunction

    initial begin
        cycle(1, 0, 0, 32'h0, 0);
        cycle(1, 1, 1, 32'hFFFF_FFFF, 0);
        cycle(0, 0, 0, 32'h0, 1);
        // R1 reset value
        check(rd_data == 32'h050A_0005, "R1 reset value", rd_data, 32'h050A_0005);

        // R7 unprivileged mixed write; R10 no change before the edge
        cycle(0, 1, 0, 32'hFA5F_F1F3, 1);
        check(rd_data == 32'h050A_0005, "R10 before edge", rd_data, 32'h050A_0005);
        cycle(0, 0, 0, 32'h0, 1);
        check(rd_data == 32'h0A0A_0003, "R7 per-field unprivileged", rd_data, 32'h0A0A_0003);
        check(sbe_evt_out == 1'b1, "R9 event passes", 32'(sbe_evt_out), 32'h1);

        // R3 privileged non-key mode write ignored, map set
        cycle(0, 1, 1, 32'h0C0C_0105, 0);
        cycle(0, 0, 0, 32'h0, 0);
        check(rd_data == 32'h0A0A_0105, "R3 non-key ignored", rd_data, 32'h0A0A_0105);
        check(corr_en == 1'b0, "R8 corr off when det off", 32'(corr_en), 32'h0);

        // R3 privileged key write to mode
        cycle(0, 1, 1, 32'h0505_0009, 1);
        cycle(0, 0, 0, 32'h0, 1);
        check(rd_data == 32'h0505_0009, "R3 privileged key", rd_data, 32'h0505_0009);
        check(sbe_evt_out == 1'b0, "R9 event blocked", 32'(sbe_evt_out), 32'h0);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] d;
            d = $urandom();
            d[27:24] = pick_nib();
            d[19:16] = pick_nib();
            d[3:0]   = pick_nib();
            cycle(($urandom_range(0, 63) == 0), ($urandom_range(0, 2) != 0),
                  1'($urandom_range(0, 1)), d, 1'($urandom_range(0, 1)));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule